// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps a wall-clock calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each accepted one-second tick starts an update. The internal count advances at once. A short update window then follows, and the externally visible time registers are refreshed from the count when that window closes. The visible values follow two format controls. One selects binary or BCD, the other selects 24-hour or 12-hour hours with a PM flag in bit 7. The alarm registers and host-loaded time use the same encoding.

At the end of every update window the block compares the new time against three alarm fields. A field whose two top bits are both set matches any value. The block latches alarm and update-ended events in an event-flag byte, which the host clears with a pulse. The tick is accepted only while a three-bit divider-control input holds the normal-operation code. A hold input freezes the visible registers while the host sets the time. The count keeps running during the hold.

Internally the count is kept in binary. Conversion to and from the selected encoding happens only at the load port, at the visible registers and at the alarm compare.

Top module: `cal_clock`

## Requirements
- R1: After reset the visible seconds, minutes, hours, day-of-week and year read 0x00, day-of-month and month read 0x01, the update-in-progress output is 0 and the event flags are 0x00.
- R2: With fmt_bin=1, every time, alarm and load byte is plain binary. With fmt_bin=0, each byte is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: With fmt_24h=1 the hour byte carries 0 to 23. With fmt_24h=0 bits 6:0 carry the hour modulo 12 and bit 7 is set from 12:00 to 23:59, so midnight reads 0x00 and noon reads 0x80 in BCD.
- R4: Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0. Day of week counts 0 to 6 and wraps. Month runs 1 to 12 and then increments the year. The year wraps from 99 to 0.
- R5: Months 4, 6, 9 and 11 have 30 days and the other months have 31, except February. February has 29 days when the year is divisible by 4 and is either nonzero or falls in a century divisible by 4 (parameter CENTURY, default 20), and 28 days otherwise.
- R6: A day of month of 0 becomes 1 at the next day rollover, and the month is left unchanged.
- R7: While div_ctl differs from 3'b010, ticks are ignored and the time does not advance.
- R8: An accepted tick with set_hold low drives uip high for UPD_CYCLES cycles. The visible time changes only when uip falls. Further ticks inside the window are ignored.
- R9: While set_hold is high, uip stays low and the visible time registers keep their value. The count still advances on each tick, so the visible time catches up at the first update after set_hold falls.
- R10: At the end of each update window with alarm_en high, the block sets bits 7 and 5 of evt_flags when the hour, minute and second fields all match the new time. A field of 0xC0 or above matches any value.
- R11: At the end of each update window with upd_en high and set_hold low, the block sets bits 7 and 4 of evt_flags.
- R12: A flag_clr pulse clears evt_flags on the next edge. If an event occurs in the same cycle, the event's bits are still set.
- R13: A load_en pulse writes all seven load bytes, taken in the current encoding. The visible registers show the loaded bytes one cycle later, and counting continues from the loaded time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| div_ctl | input | 3 | Divider control; 3'b010 enables counting |
| set_hold | input | 1 | Hold visible registers during host time set |
| fmt_bin | input | 1 | 1 = binary, 0 = BCD |
| fmt_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_en | input | 1 | Alarm event enable |
| upd_en | input | 1 | Update-ended event enable |
| alm_sec | input | 8 | Alarm seconds field |
| alm_min | input | 8 | Alarm minutes field |
| alm_hour | input | 8 | Alarm hours field |
| load_en | input | 1 | Load pulse for host-set time |
| ld_sec | input | 8 | Loaded seconds |
| ld_min | input | 8 | Loaded minutes |
| ld_hour | input | 8 | Loaded hours |
| ld_wday | input | 8 | Loaded day of week |
| ld_mday | input | 8 | Loaded day of month |
| ld_mon | input | 8 | Loaded month |
| ld_year | input | 8 | Loaded year |
| flag_clr | input | 1 | Clear event flags |
| out_sec | output | 8 | Visible seconds |
| out_min | output | 8 | Visible minutes |
| out_hour | output | 8 | Visible hours |
| out_wday | output | 8 | Visible day of week |
| out_mday | output | 8 | Visible day of month |
| out_mon | output | 8 | Visible month |
| out_year | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| evt_flags | output | 8 | Event flags: bit 7 any, bit 5 alarm, bit 4 update ended |

## Verification
A wrong carry in the internal count does not appear while it happens. It appears at the next falling edge of uip, UPD_CYCLES cycles after the tick, as a wrong field in one of the visible bytes. For that reason every calendar vector loads a time one second before a boundary and compares all seven bytes once the window has closed. A wrong decode of the alarm or load encoding shows up in the same window as a missing or extra alarm bit, or as a wrong loaded byte one cycle after load_en. Errors in the hold and divider gates show up as the seconds byte moving, or failing to move, over a whole window.

// File: rtl/cal_pkg.sv
package cal_pkg;

    // Internal calendar count, binary, one 7-bit field per unit
    typedef struct packed {
        logic [6:0] year;
        logic [6:0] mon;
        logic [6:0] mday;
        logic [6:0] wday;
        logic [6:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    // Visible byte registers, in the selected encoding
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_view_t;

    localparam logic [2:0] DIV_NORMAL  = 3'b010;
    localparam logic [7:0] WILD_MASK   = 8'hC0;
    localparam logic [7:0] EVT_ALARM   = 8'hA0;
    localparam logic [7:0] EVT_UPDATED = 8'h90;

    localparam cal_time_t TIME_RESET = '{year: 7'd0, mon: 7'd1, mday: 7'd1,
                                         wday: 7'd0, hour: 7'd0, min: 7'd0,
                                         sec: 7'd0};

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return bin ? {1'b0, v} : {tens, ones};
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] r, input logic bin);
        logic [6:0] hi;
        logic [6:0] lo;
        hi = {3'b000, r[7:4]};
        lo = {3'b000, r[3:0]};
        return bin ? r[6:0] : (hi * 7'd10) + lo;
    endfunction

    function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin,
                                            input logic h24);
        logic       pm;
        logic [6:0] hh;
        logic [7:0] e;
        pm = (h >= 7'd12);
        hh = pm ? h - 7'd12 : h;
        e  = enc_val(h24 ? h : hh, bin);
        return h24 ? e : {pm, e[6:0]};
    endfunction

    function automatic logic [6:0] dec_hour(input logic [7:0] r, input logic bin,
                                            input logic h24);
        logic [6:0] v;
        v = dec_val({1'b0, r[6:0]}, bin);
        if (h24)
            return dec_val(r, bin);
        return r[7] ? v + 7'd12 : v;
    endfunction

    function automatic logic is_leap(input logic [6:0] y, input logic cent_div4);
        return (y[1:0] == 2'b00) && ((y != 7'd0) || cent_div4);
    endfunction

    function automatic logic [6:0] days_in(input logic [6:0] mon, input logic leap);
        case (mon)
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            7'd2:                    return leap ? 7'd29 : 7'd28;
            default:                 return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq #(
    parameter int UPD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [2:0] div_ctl,
    input  logic       set_hold,
    output logic       adv,
    output logic       fin,
    output logic       uip
);
    import cal_pkg::*;

    localparam int CW = $clog2(UPD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

    logic          busy;
    logic [CW-1:0] cnt;

    assign adv = sec_tick && (div_ctl == DIV_NORMAL) && !busy;
    assign fin = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            uip  <= 1'b0;
        end else begin
            if (adv) begin
                busy <= 1'b1;
                cnt  <= LAST;
                uip  <= !set_hold;
            end else if (fin) begin
                busy <= 1'b0;
                uip  <= 1'b0;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
                if (set_hold)
                    uip <= 1'b0;
            end
        end
    end

    AST_UIP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        uip |-> busy);                                                // R8
    AST_ADV_OPENS: assert property (@(posedge clk) disable iff (rst)
        adv |=> (busy && uip == !$past(set_hold)));                   // R8
    AST_HOLD_NO_UIP: assert property (@(posedge clk) disable iff (rst)
        (set_hold && !adv) |=> !uip);                                 // R9

endmodule

// File: rtl/cal_counter.sv
module cal_counter #(
    parameter int CENTURY = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               ld,
    input  cal_pkg::cal_time_t ld_time,
    output cal_pkg::cal_time_t cur
);
    import cal_pkg::*;

    localparam logic CENT_DIV4 = ((CENTURY % 4) == 0);

    cal_time_t nxt;
    logic [6:0] dim;

    always_comb begin
        nxt = cur;
        dim = days_in(cur.mon, is_leap(cur.year, CENT_DIV4));
        if (cur.sec < 7'd59) begin
            nxt.sec = cur.sec + 7'd1;
        end else begin
            nxt.sec = 7'd0;
            if (cur.min < 7'd59) begin
                nxt.min = cur.min + 7'd1;
            end else begin
                nxt.min = 7'd0;
                if (cur.hour < 7'd23) begin
                    nxt.hour = cur.hour + 7'd1;
                end else begin
                    nxt.hour = 7'd0;
                    nxt.wday = (cur.wday < 7'd6) ? cur.wday + 7'd1 : 7'd0;
                    if (cur.mday == 7'd0) begin
                        nxt.mday = 7'd1;
                    end else if (cur.mday < dim) begin
                        nxt.mday = cur.mday + 7'd1;
                    end else begin
                        nxt.mday = 7'd1;
                        if (cur.mon < 7'd12) begin
                            nxt.mon = cur.mon + 7'd1;
                        end else begin
                            nxt.mon  = 7'd1;
                            nxt.year = (cur.year < 7'd99) ? cur.year + 7'd1 : 7'd0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= TIME_RESET;
        else if (ld)
            cur <= ld_time;
        else if (adv)
            cur <= nxt;
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !ld) |=> $stable(cur));                              // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld && cur.sec == 7'd59) |=> (cur.sec == 7'd0));      // R4
    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld && cur.wday < 7'd7) |=> (cur.wday < 7'd7));       // R4

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm (
    input  logic               clk,
    input  logic               rst,
    input  logic               fin,
    input  logic               set_hold,
    input  logic               alarm_en,
    input  logic               upd_en,
    input  logic               fmt_bin,
    input  logic               fmt_24h,
    input  logic [7:0]         alm_sec,
    input  logic [7:0]         alm_min,
    input  logic [7:0]         alm_hour,
    input  cal_pkg::cal_time_t cur,
    input  logic               clr,
    output logic [7:0]         flags
);
    import cal_pkg::*;

    logic s_ok, m_ok, h_ok, hit;
    logic [7:0] set_bits;

    always_comb begin
        s_ok = ((alm_sec & WILD_MASK) == WILD_MASK) ||
               (dec_val(alm_sec, fmt_bin) == cur.sec);
        m_ok = ((alm_min & WILD_MASK) == WILD_MASK) ||
               (dec_val(alm_min, fmt_bin) == cur.min);
        h_ok = ((alm_hour & WILD_MASK) == WILD_MASK) ||
               (dec_hour(alm_hour, fmt_bin, fmt_24h) == cur.hour);
        hit  = s_ok && m_ok && h_ok;
        set_bits = 8'h00;
        if (fin && alarm_en && hit)
            set_bits = set_bits | EVT_ALARM;
        if (fin && upd_en && !set_hold)
            set_bits = set_bits | EVT_UPDATED;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= 8'h00;
        else
            flags <= (clr ? 8'h00 : flags) | set_bits;
    end

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!fin && !clr) |=> $stable(flags));                           // R10
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (clr && !fin) |=> (flags == 8'h00));                          // R12

endmodule

// File: rtl/cal_clock.sv
module cal_clock #(
    parameter int UPD_CYCLES = 8,
    parameter int CENTURY    = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [2:0] div_ctl,
    input  logic       set_hold,
    input  logic       fmt_bin,
    input  logic       fmt_24h,
    input  logic       alarm_en,
    input  logic       upd_en,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    input  logic       flag_clr,
    output logic [7:0] out_sec,
    output logic [7:0] out_min,
    output logic [7:0] out_hour,
    output logic [7:0] out_wday,
    output logic [7:0] out_mday,
    output logic [7:0] out_mon,
    output logic [7:0] out_year,
    output logic       uip,
    output logic [7:0] evt_flags
);
    import cal_pkg::*;

    localparam cal_view_t VIEW_RESET = '{year: 8'h00, mon: 8'h01, mday: 8'h01,
                                         wday: 8'h00, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    logic      adv, fin;
    cal_time_t cur, ld_time;
    cal_view_t vis, fresh;

    always_comb begin
        ld_time.sec  = dec_val(ld_sec,  fmt_bin);
        ld_time.min  = dec_val(ld_min,  fmt_bin);
        ld_time.hour = dec_hour(ld_hour, fmt_bin, fmt_24h);
        ld_time.wday = dec_val(ld_wday, fmt_bin);
        ld_time.mday = dec_val(ld_mday, fmt_bin);
        ld_time.mon  = dec_val(ld_mon,  fmt_bin);
        ld_time.year = dec_val(ld_year, fmt_bin);
    end

    always_comb begin
        fresh.sec  = enc_val(cur.sec,  fmt_bin);
        fresh.min  = enc_val(cur.min,  fmt_bin);
        fresh.hour = enc_hour(cur.hour, fmt_bin, fmt_24h);
        fresh.wday = enc_val(cur.wday, fmt_bin);
        fresh.mday = enc_val(cur.mday, fmt_bin);
        fresh.mon  = enc_val(cur.mon,  fmt_bin);
        fresh.year = enc_val(cur.year, fmt_bin);
    end

    cal_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .div_ctl  (div_ctl),
        .set_hold (set_hold),
        .adv      (adv),
        .fin      (fin),
        .uip      (uip)
    );

    cal_counter #(.CENTURY(CENTURY)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .ld      (load_en),
        .ld_time (ld_time),
        .cur     (cur)
    );

    cal_alarm u_alm (
        .clk      (clk),
        .rst      (rst),
        .fin      (fin),
        .set_hold (set_hold),
        .alarm_en (alarm_en),
        .upd_en   (upd_en),
        .fmt_bin  (fmt_bin),
        .fmt_24h  (fmt_24h),
        .alm_sec  (alm_sec),
        .alm_min  (alm_min),
        .alm_hour (alm_hour),
        .cur      (cur),
        .clr      (flag_clr),
        .flags    (evt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            vis <= VIEW_RESET;
        else if (load_en)
            vis <= '{year: ld_year, mon: ld_mon, mday: ld_mday, wday: ld_wday,
                     hour: ld_hour, min: ld_min, sec: ld_sec};
        else if (fin && !set_hold)
            vis <= fresh;
    end

    assign out_sec  = vis.sec;
    assign out_min  = vis.min;
    assign out_hour = vis.hour;
    assign out_wday = vis.wday;
    assign out_mday = vis.mday;
    assign out_mon  = vis.mon;
    assign out_year = vis.year;

    AST_VIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (set_hold && !load_en) |=> $stable(vis));                     // R9
    AST_VIS_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        (!fin && !load_en) |=> $stable(vis));                         // R8
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (vis.sec == $past(ld_sec)));                      // R13

endmodule

// File: tb/test_cal_clock.sv
module test_cal_clock;

    localparam int UPD = 6;
    localparam int NV  = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, sec_tick, set_hold, fmt_bin, fmt_24h, alarm_en, upd_en;
    logic       load_en, flag_clr;
    logic [2:0] div_ctl;
    logic [7:0] alm_sec, alm_min, alm_hour;
    logic [7:0] ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year;
    logic [7:0] out_sec, out_min, out_hour, out_wday, out_mday, out_mon, out_year;
    logic       uip;
    logic [7:0] evt_flags;

    int checks = 0;
    int errors = 0;
    logic mid_uip;
    logic done = 1'b0;

    cal_clock #(.UPD_CYCLES(UPD), .CENTURY(20)) i_cal_clock (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .div_ctl(div_ctl),
        .set_hold(set_hold), .fmt_bin(fmt_bin), .fmt_24h(fmt_24h),
        .alarm_en(alarm_en), .upd_en(upd_en),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
        .flag_clr(flag_clr),
        .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour),
        .out_wday(out_wday), .out_mday(out_mday), .out_mon(out_mon),
        .out_year(out_year), .uip(uip), .evt_flags(evt_flags)
    );

    // {bin, h24, load sec..year, expected sec..year}
    localparam logic [113:0] VEC [NV] = '{
        {2'b01, 56'h59_59_23_06_31_12_23, 56'h00_00_00_00_01_01_24}, // R4 year carry
        {2'b01, 56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R5 leap Feb 28
        {2'b01, 56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24}, // R5 leap Feb 29
        {2'b01, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23}, // R5 common Feb
        {2'b01, 56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00}, // R5 year 00
        {2'b11, 56'h3B_3B_17_05_1E_04_63, 56'h00_00_00_06_01_05_63}, // R2 binary, 30-day
        {2'b00, 56'h59_59_11_02_15_06_25, 56'h00_00_80_02_15_06_25}, // R3 noon
        {2'b00, 56'h59_59_91_02_15_06_25, 56'h00_00_00_03_16_06_25}, // R3 midnight
        {2'b10, 56'h3B_3B_8B_06_0A_03_14, 56'h00_00_00_00_0B_03_14}, // R3 binary 12h
        {2'b01, 56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_01_00}, // R4 year wrap
        {2'b01, 56'h59_59_23_01_00_05_30, 56'h00_00_00_02_01_05_30}, // R6 day zero
        {2'b01, 56'h56_34_12_03_15_06_24, 56'h57_34_12_03_15_06_24}  // R2 plain second
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_time(input logic [55:0] v);
        @(negedge clk);
        {ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year} = v;
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic one_sec();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        mid_uip = uip;
        repeat (UPD) @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    function automatic logic [55:0] view();
        return {out_sec, out_min, out_hour, out_wday, out_mday, out_mon, out_year};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sec_tick = 1'b0; div_ctl = 3'b010; set_hold = 1'b0;
        fmt_bin = 1'b0; fmt_24h = 1'b1; alarm_en = 1'b0; upd_en = 1'b0;
        alm_sec = 8'h00; alm_min = 8'h00; alm_hour = 8'h00;
        load_en = 1'b0; flag_clr = 1'b0;
        {ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_mon, ld_year} = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 time", {8'h0, view()}, {8'h0, 56'h00_00_00_00_01_01_00});
        chk("R1 uip/flags", {55'h0, uip, evt_flags}, 64'h0);

        // Vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {fmt_bin, fmt_24h} = VEC[i][113:112];
            load_time(VEC[i][111:56]);
            one_sec();
            chk($sformatf("R4/R5 vector %0d", i), {8'h0, view()}, {8'h0, VEC[i][55:0]});
        end

        // R13 load visible next cycle
        fmt_bin = 1'b0; fmt_24h = 1'b1;
        load_time(56'h00_00_12_01_15_06_24);
        chk("R13 load", {8'h0, view()}, {8'h0, 56'h00_00_12_01_15_06_24});

        // R8 uip framing and ignored tick inside window
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        mid_uip = uip;
        chk("R8 sec unchanged in window", {56'h0, out_sec}, 64'h00);
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        repeat (UPD - 2) @(negedge clk);
        chk("R8 uip mid", {63'h0, mid_uip}, 64'h1);
        chk("R8 uip end", {63'h0, uip}, 64'h0);
        chk("R8 single advance", {56'h0, out_sec}, 64'h01);

        // R7 divider stopped
        div_ctl = 3'b000;
        one_sec();
        chk("R7 no advance", {56'h0, out_sec}, 64'h01);
        chk("R7 no uip", {63'h0, mid_uip}, 64'h0);
        div_ctl = 3'b010;
        one_sec();
        chk("R7 restored", {56'h0, out_sec}, 64'h02);

        // R9 hold
        set_hold = 1'b1;
        one_sec();
        chk("R9 held", {56'h0, out_sec}, 64'h02);
        chk("R9 no uip", {63'h0, mid_uip}, 64'h0);
        set_hold = 1'b0;
        one_sec();
        chk("R9 catch up", {56'h0, out_sec}, 64'h04);

        // R10 alarm exact match (time becomes 12:00:05)
        alarm_en = 1'b1;
        alm_sec = 8'h05; alm_min = 8'h00; alm_hour = 8'h12;
        one_sec();
        chk("R10 exact", {56'h0, evt_flags}, 64'hA0);
        clear_flags();
        chk("R12 clear", {56'h0, evt_flags}, 64'h00);

        // R10 wildcard (12:00:06)
        alm_sec = 8'hC0; alm_min = 8'hFF; alm_hour = 8'h12;
        one_sec();
        chk("R10 wildcard", {56'h0, evt_flags}, 64'hA0);
        clear_flags();

        // R10 mismatch (12:00:07)
        alm_sec = 8'h09; alm_min = 8'h00; alm_hour = 8'h12;
        one_sec();
        chk("R10 mismatch", {56'h0, evt_flags}, 64'h00);

        // R10 disabled with all wildcards
        alarm_en = 1'b0;
        alm_sec = 8'hFF; alm_min = 8'hFF; alm_hour = 8'hFF;
        one_sec();
        chk("R10 disabled", {56'h0, evt_flags}, 64'h00);

        // R11 update ended
        upd_en = 1'b1;
        one_sec();
        chk("R11 update", {56'h0, evt_flags}, 64'h90);
        clear_flags();
        set_hold = 1'b1;
        one_sec();
        chk("R11 hold suppresses", {56'h0, evt_flags}, 64'h00);
        set_hold = 1'b0;

        // R12 event wins over simultaneous clear: pulse clear at window end
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        repeat (UPD - 1) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R12 event wins", {56'h0, evt_flags}, 64'h90);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule